// File: doc/BRIEF.md
# Instruction Cache Parity Guard

This block sits on the read path of an instruction cache. Each lookup brings in one data word and one tag word, along with the set, the way and the bank each word was read from. The block checks every word for parity before the word reaches the fetch unit.

The data word holds two instruction halves, and each half carries its own even-parity bit. The tag word carries one even-parity bit. A clean lookup is passed on with its parity bits removed. A bad word, in either array, is never corrected and never forwarded. Instead the block does four things:

- It invalidates the addressed line and its paired line.
- It pulses an error report that names the offending RAM.
- It raises a refetch request toward the next memory level.
- It holds off new lookups until that request is acknowledged.

Top module: `icache_parity_guard`

## Requirements
- R1: After reset, all valid, pulse and request outputs are low and `rdReady` is high.
- R2: A lookup captured at one clock edge with good parity produces a one-cycle `fetchValid` after the next edge. `fetchInsn` equals data bits 40:21 above bits 19:0, and `fetchTag` equals tag bits 30:0.
- R3: Parity is even. Bit 41 makes bits 41:21 hold an even number of ones. A word that breaks this is treated as bad.
- R4: Bit 20 makes bits 20:0 hold an even number of ones. A word that breaks this is treated as bad.
- R5: Tag bit 31 makes bits 31:0 hold an even number of ones. A tag that breaks this is treated as bad.
- R6: A bad lookup never raises `fetchValid`. Instead it raises `invValid` for one cycle, with `invSet` set to the lookup's set. `invWayMask` has exactly two bits set: bit `way` and bit `way XOR 1`.
- R7: A bad lookup gives a one-cycle `errValid` in the same cycle as `invValid`. For a data error, `errRamId` is the data bank (0 to 3) and `errIsTag` is 0. For a tag error, `errRamId` is 4 plus the tag bank and `errIsTag` is 1. When both words are bad, the tag report wins.
- R8: `refetchReq` rises in the same cycle as the error pulse. It stays high, with `refetchSet` and `refetchWay` stable at the bad lookup's index, until a cycle in which `refetchAck` is high.
- R9: While a refetch is outstanding, `rdReady` is low and `rdValid` is ignored: no fetch, no error report and no invalidate results.
- R10: `refetchReq` falls and `rdReady` returns high right after the edge that samples `refetchAck`. A following clean lookup is then delivered normally.
- R11: Clean lookups presented on consecutive cycles are all accepted and delivered, one per cycle, in order.
- R12: `refetchAck` with no request outstanding has no effect.
- R13: A word with one bad bit in each half is still reported as a single data error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rdValid | input | 1 | Read words and index are valid |
| rdReady | output | 1 | Block accepts a lookup this cycle |
| rdData | input | 42 | Data RAM word (two halves, each with parity) |
| rdTag | input | 32 | Tag RAM word with parity |
| rdSet | input | 6 | Set index of the lookup |
| rdWay | input | 2 | Way of the lookup |
| rdDataBank | input | 2 | Data RAM bank that supplied the word |
| rdTagBank | input | 1 | Tag RAM bank that supplied the tag |
| fetchValid | output | 1 | Clean instruction word available |
| fetchInsn | output | 40 | Instruction bits with parity removed |
| fetchTag | output | 31 | Tag bits with parity removed |
| invValid | output | 1 | Invalidate pulse |
| invSet | output | 6 | Set to invalidate |
| invWayMask | output | 4 | Ways to invalidate |
| refetchReq | output | 1 | Refetch request to the next level |
| refetchAck | input | 1 | Refetch acknowledge |
| refetchSet | output | 6 | Set to refetch |
| refetchWay | output | 2 | Way to refetch |
| errValid | output | 1 | Error report pulse |
| errRamId | output | 3 | RAM identifier of the error |
| errIsTag | output | 1 | 1 for tag error, 0 for data error |

## Verification
A stage register that loses its valid bit shows up as a missing `fetchValid` or error pulse exactly one edge after capture. A wrong refetch state is visible right away: `rdReady` and `refetchReq` fail to mirror each other, or a lookup is accepted while a request is open. Errors in the parity or mask logic show up in the same pulse cycle, as a wrong `errRamId`, a wrong `errIsTag` or a wrong `invWayMask`.

// File: rtl/icpar_pkg.sv
package icpar_pkg;

  typedef struct packed {
    logic capture;   // load the stage register from the read port
    logic loadFetch; // load the fetch output registers
    logic loadErr;   // load the error, invalidate and refetch index registers
  } icparStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } icparState_t;

endpackage

// File: rtl/icpar_datapath.sv
module icpar_datapath
  import icpar_pkg::*;
#(
  parameter int HALF_W     = 20,
  parameter int TAG_W      = 31,
  parameter int SETS       = 64,
  parameter int WAYS       = 4,
  parameter int DATA_BANKS = 4,
  parameter int TAG_BANKS  = 2,
  parameter int ID_W       = 3
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  icparStrobe_t                           strobe,
  input  logic [2*(HALF_W+1)-1:0]                rdData,
  input  logic [TAG_W:0]                         rdTag,
  input  logic [$clog2(SETS)-1:0]                rdSet,
  input  logic [$clog2(WAYS)-1:0]                rdWay,
  input  logic [$clog2(DATA_BANKS)-1:0]          rdDataBank,
  input  logic [(TAG_BANKS>1?$clog2(TAG_BANKS):1)-1:0] rdTagBank,
  output logic                                   dataErr,
  output logic                                   tagErr,
  output logic [2*HALF_W-1:0]                    fetchInsn,
  output logic [TAG_W-1:0]                       fetchTag,
  output logic [ID_W-1:0]                        errRamId,
  output logic                                   errIsTag,
  output logic [$clog2(SETS)-1:0]                invSet,
  output logic [WAYS-1:0]                        invWayMask,
  output logic [$clog2(SETS)-1:0]                refetchSet,
  output logic [$clog2(WAYS)-1:0]                refetchWay
);
  localparam int SEG_W   = HALF_W + 1;
  localparam int DATA_W  = 2 * SEG_W;
  localparam int SET_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int DBANK_W = $clog2(DATA_BANKS);
  localparam int TBANK_W = (TAG_BANKS > 1) ? $clog2(TAG_BANKS) : 1;

  logic [DATA_W-1:0]  stData;
  logic [TAG_W:0]     stTag;
  logic [SET_W-1:0]   stSet;
  logic [WAY_W-1:0]   stWay;
  logic [DBANK_W-1:0] stDataBank;
  logic [TBANK_W-1:0] stTagBank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stData     <= '0;
      stTag      <= '0;
      stSet      <= '0;
      stWay      <= '0;
      stDataBank <= '0;
      stTagBank  <= '0;
    end else if (strobe.capture) begin
      stData     <= rdData;
      stTag      <= rdTag;
      stSet      <= rdSet;
      stWay      <= rdWay;
      stDataBank <= rdDataBank;
      stTagBank  <= rdTagBank;
    end
  end

  // Per-half even parity check; each segment is the half plus its parity bit on top.
  logic [1:0]              segErr;
  logic [2*HALF_W-1:0]     stInsn;
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign segErr[h] = ^stData[h*SEG_W +: SEG_W];
    assign stInsn[h*HALF_W +: HALF_W] = stData[h*SEG_W +: HALF_W];
  end

  assign dataErr = |segErr;
  assign tagErr  = ^stTag;

  // Two-line invalidate mask: the accessed way and its pair.
  logic [WAYS-1:0] pairMask;
  for (genvar w = 0; w < WAYS; w++) begin : g_mask
    assign pairMask[w] = (WAY_W'(w) == stWay) || (WAY_W'(w) == (stWay ^ WAY_W'(1)));
  end

  logic [ID_W-1:0] ramIdNext;
  always_comb begin
    if (tagErr) ramIdNext = ID_W'(DATA_BANKS) + ID_W'(stTagBank);
    else        ramIdNext = ID_W'(stDataBank);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchInsn <= '0;
      fetchTag  <= '0;
    end else if (strobe.loadFetch) begin
      fetchInsn <= stInsn;
      fetchTag  <= stTag[TAG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errRamId   <= '0;
      errIsTag   <= 1'b0;
      invSet     <= '0;
      invWayMask <= '0;
      refetchSet <= '0;
      refetchWay <= '0;
    end else if (strobe.loadErr) begin
      errRamId   <= ramIdNext;
      errIsTag   <= tagErr;
      invSet     <= stSet;
      invWayMask <= pairMask;
      refetchSet <= stSet;
      refetchWay <= stWay;
    end
  end

endmodule

// File: rtl/icpar_ctrl.sv
module icpar_ctrl
  import icpar_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rdValid,
  input  logic         dataErr,
  input  logic         tagErr,
  input  logic         refetchAck,
  output logic         rdReady,
  output icparStrobe_t strobe,
  output logic         fetchValid,
  output logic         invValid,
  output logic         errValid,
  output logic         refetchReq
);
  icparState_t state;
  logic        stValid;
  logic        stBad;

  assign stBad   = stValid && (dataErr || tagErr);
  assign rdReady = (state == ST_IDLE) && !stBad;

  always_comb begin
    strobe           = '0;
    strobe.capture   = rdValid && rdReady;
    strobe.loadFetch = stValid && !stBad;
    strobe.loadErr   = stBad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      stValid    <= 1'b0;
      fetchValid <= 1'b0;
      invValid   <= 1'b0;
      errValid   <= 1'b0;
    end else begin
      stValid    <= strobe.capture;
      fetchValid <= strobe.loadFetch;
      invValid   <= stBad;
      errValid   <= stBad;
      case (state)
        ST_IDLE: if (stBad)      state <= ST_WAIT;
        ST_WAIT: if (refetchAck) state <= ST_IDLE;
        default:                 state <= ST_IDLE;
      endcase
    end
  end

  assign refetchReq = (state == ST_WAIT);

endmodule

// File: rtl/icache_parity_guard.sv
module icache_parity_guard
  import icpar_pkg::*;
#(
  parameter int HALF_W     = 20,
  parameter int TAG_W      = 31,
  parameter int SETS       = 64,
  parameter int WAYS       = 4,
  parameter int DATA_BANKS = 4,
  parameter int TAG_BANKS  = 2,
  parameter int ID_W       = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        rdValid,
  output logic                        rdReady,
  input  logic [2*(HALF_W+1)-1:0]     rdData,
  input  logic [TAG_W:0]              rdTag,
  input  logic [$clog2(SETS)-1:0]     rdSet,
  input  logic [$clog2(WAYS)-1:0]     rdWay,
  input  logic [$clog2(DATA_BANKS)-1:0] rdDataBank,
  input  logic [(TAG_BANKS>1?$clog2(TAG_BANKS):1)-1:0] rdTagBank,
  output logic                        fetchValid,
  output logic [2*HALF_W-1:0]         fetchInsn,
  output logic [TAG_W-1:0]            fetchTag,
  output logic                        invValid,
  output logic [$clog2(SETS)-1:0]     invSet,
  output logic [WAYS-1:0]             invWayMask,
  output logic                        refetchReq,
  input  logic                        refetchAck,
  output logic [$clog2(SETS)-1:0]     refetchSet,
  output logic [$clog2(WAYS)-1:0]     refetchWay,
  output logic                        errValid,
  output logic [ID_W-1:0]             errRamId,
  output logic                        errIsTag
);
  icparStrobe_t strobe;
  logic         dataErr;
  logic         tagErr;

  icpar_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rdValid    (rdValid),
    .dataErr    (dataErr),
    .tagErr     (tagErr),
    .refetchAck (refetchAck),
    .rdReady    (rdReady),
    .strobe     (strobe),
    .fetchValid (fetchValid),
    .invValid   (invValid),
    .errValid   (errValid),
    .refetchReq (refetchReq)
  );

  icpar_datapath #(
    .HALF_W     (HALF_W),
    .TAG_W      (TAG_W),
    .SETS       (SETS),
    .WAYS       (WAYS),
    .DATA_BANKS (DATA_BANKS),
    .TAG_BANKS  (TAG_BANKS),
    .ID_W       (ID_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rdData     (rdData),
    .rdTag      (rdTag),
    .rdSet      (rdSet),
    .rdWay      (rdWay),
    .rdDataBank (rdDataBank),
    .rdTagBank  (rdTagBank),
    .dataErr    (dataErr),
    .tagErr     (tagErr),
    .fetchInsn  (fetchInsn),
    .fetchTag   (fetchTag),
    .errRamId   (errRamId),
    .errIsTag   (errIsTag),
    .invSet     (invSet),
    .invWayMask (invWayMask),
    .refetchSet (refetchSet),
    .refetchWay (refetchWay)
  );

endmodule

// File: rtl/icache_parity_guard_chk.sv
module icache_parity_guard_chk #(
  parameter int SET_W      = 6,
  parameter int WAYS       = 4,
  parameter int DATA_BANKS = 4,
  parameter int ID_W       = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdReady,
  input logic             fetchValid,
  input logic             invValid,
  input logic [WAYS-1:0]  invWayMask,
  input logic             errValid,
  input logic [ID_W-1:0]  errRamId,
  input logic             errIsTag,
  input logic             refetchReq,
  input logic             refetchAck,
  input logic [SET_W-1:0] refetchSet
);
  a_r6_no_fetch_on_err: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> !fetchValid);
  a_r6_two_lines: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> ($countones(invWayMask) == 2));
  a_r7_err_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    errValid |=> !errValid);
  a_r7_tag_id: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && errIsTag) |-> (errRamId >= ID_W'(DATA_BANKS)));
  a_r7_data_id: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && !errIsTag) |-> (errRamId < ID_W'(DATA_BANKS)));
  a_r8_req_from_err: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refetchReq) |-> errValid);
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (refetchReq && !refetchAck) |=> refetchReq);
  a_r8_index_stable: assert property (@(posedge clk) disable iff (!rstN)
    (refetchReq && !refetchAck) |=> $stable(refetchSet));
  a_r9_stall: assert property (@(posedge clk) disable iff (!rstN)
    refetchReq |-> !rdReady);
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (refetchReq && $past(refetchReq)) |-> !(fetchValid || errValid));
endmodule

bind icache_parity_guard icache_parity_guard_chk #(
  .SET_W      ($clog2(SETS)),
  .WAYS       (WAYS),
  .DATA_BANKS (DATA_BANKS),
  .ID_W       (ID_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rdReady    (rdReady),
  .fetchValid (fetchValid),
  .invValid   (invValid),
  .invWayMask (invWayMask),
  .errValid   (errValid),
  .errRamId   (errRamId),
  .errIsTag   (errIsTag),
  .refetchReq (refetchReq),
  .refetchAck (refetchAck),
  .refetchSet (refetchSet)
);

// File: tb/test_icache_parity_guard.sv
module test_icache_parity_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdValid = 1'b0;
  logic        rdReady;
  logic [41:0] rdData = '0;
  logic [31:0] rdTag = '0;
  logic [5:0]  rdSet = '0;
  logic [1:0]  rdWay = '0;
  logic [1:0]  rdDataBank = '0;
  logic [0:0]  rdTagBank = '0;
  logic        fetchValid;
  logic [39:0] fetchInsn;
  logic [30:0] fetchTag;
  logic        invValid;
  logic [5:0]  invSet;
  logic [3:0]  invWayMask;
  logic        refetchReq;
  logic        refetchAck = 1'b0;
  logic [5:0]  refetchSet;
  logic [1:0]  refetchWay;
  logic        errValid;
  logic [2:0]  errRamId;
  logic        errIsTag;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  icache_parity_guard i_icache_parity_guard (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finishRun();
    end
  end

  function automatic logic [41:0] mkData(input logic [19:0] hi, input logic [19:0] lo,
                                         input bit badHi, input bit badLo);
    return {(^hi) ^ badHi, hi, (^lo) ^ badLo, lo};
  endfunction

  function automatic logic [31:0] mkTag(input logic [30:0] t, input bit bad);
    return {(^t) ^ bad, t};
  endfunction

  function automatic logic [3:0] pairOf(input logic [1:0] w);
    logic [3:0] m = '0;
    m[w] = 1'b1;
    m[w ^ 2'd1] = 1'b1;
    return m;
  endfunction

  // Present one lookup at the next edge, then sample one edge later.
  task automatic lookup(input logic [41:0] d, input logic [31:0] t, input logic [5:0] s,
                        input logic [1:0] w, input logic [1:0] db, input logic tb);
    @(negedge clk);
    rdData = d; rdTag = t; rdSet = s; rdWay = w; rdDataBank = db; rdTagBank = tb;
    rdValid = 1'b1;
    @(posedge clk); #1;
    rdValid = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic ackRefetch();
    @(negedge clk);
    refetchAck = 1'b1;
    @(posedge clk); #1;
    refetchAck = 1'b0;
  endtask

  task automatic testReset();
    check(rdReady == 1'b1, "R1 rdReady", rdReady, 1);
    check({fetchValid, invValid, errValid, refetchReq} == 4'b0, "R1 outputs idle",
          {fetchValid, invValid, errValid, refetchReq}, 0);
  endtask

  task automatic testClean();
    logic [19:0] hi = 20'hA5C3F;
    logic [19:0] lo = 20'h1234E;
    logic [30:0] t  = 31'h2BADF00D;
    lookup(mkData(hi, lo, 0, 0), mkTag(t, 0), 6'd17, 2'd2, 2'd1, 1'b0);
    check(fetchValid == 1'b1, "R2 fetchValid", fetchValid, 1);
    check(fetchInsn == {hi, lo}, "R2 fetchInsn", fetchInsn, {hi, lo});
    check(fetchTag == t, "R2 fetchTag", fetchTag, t);
    check(errValid == 1'b0, "R2 no error", errValid, 0);
    @(posedge clk); #1;
    check(fetchValid == 1'b0, "R2 one-cycle pulse", fetchValid, 0);
  endtask

  task automatic testBadData(input bit badHi, input bit badLo, input logic [1:0] bank,
                             input logic [1:0] way, input logic [5:0] set, input string req);
    lookup(mkData(20'h0F0F1, 20'h33333, badHi, badLo), mkTag(31'h1, 0), set, way, bank, 1'b1);
    check(fetchValid == 1'b0, {req, " no fetch"}, fetchValid, 0);
    check(errValid && !errIsTag && errRamId == {1'b0, bank}, {req, " data err report"},
          {errValid, errIsTag, errRamId}, {1'b1, 1'b0, 1'b0, bank});
    check(invValid && invSet == set && invWayMask == pairOf(way), "R6 invalidate pair",
          {invValid, invSet, invWayMask}, {1'b1, set, pairOf(way)});
    check(refetchReq && refetchSet == set && refetchWay == way, "R8 refetch raised",
          {refetchReq, refetchSet, refetchWay}, {1'b1, set, way});
    check(rdReady == 1'b0, "R9 stalled", rdReady, 0);
    @(posedge clk); #1;
    check(!errValid && !invValid, "R7 one-cycle pulse", {errValid, invValid}, 0);
    check(refetchReq && refetchSet == set, "R8 request held", {refetchReq, refetchSet}, {1'b1, set});
    ackRefetch();
    check(!refetchReq && rdReady, "R10 released", {refetchReq, rdReady}, 2'b01);
  endtask

  task automatic testBadTag(input bit dataToo, input logic tb, input string req);
    lookup(mkData(20'h1, 20'h2, dataToo, 0), mkTag(31'h55AA55AA, 1), 6'd5, 2'd1, 2'd3, tb);
    check(fetchValid == 1'b0, {req, " no fetch"}, fetchValid, 0);
    check(errValid && errIsTag && errRamId == 3'd4 + tb, {req, " tag report"},
          {errValid, errIsTag, errRamId}, {2'b11, 3'd4 + 3'(tb)});
    check(invWayMask == 4'b0011, "R6 mask way1", invWayMask, 4'b0011);
    ackRefetch();
  endtask

  task automatic testStallIgnored();
    lookup(mkData(20'h7, 20'h8, 1, 0), mkTag(31'h9, 0), 6'd40, 2'd3, 2'd0, 1'b0);
    check(refetchReq == 1'b1, "R9 request open", refetchReq, 1);
    @(negedge clk);
    rdData = mkData(20'hFFFFF, 20'h0, 0, 0); rdTag = mkTag(31'h3, 1); rdValid = 1'b1;
    repeat (3) begin
      @(posedge clk); #1;
      check(!fetchValid && !errValid && !invValid && !rdReady, "R9 rdValid ignored",
            {fetchValid, errValid, invValid, rdReady}, 0);
    end
    rdValid = 1'b0;
    check(refetchSet == 6'd40 && refetchWay == 2'd3, "R8 index kept",
          {refetchSet, refetchWay}, {6'd40, 2'd3});
    ackRefetch();
    lookup(mkData(20'hABCDE, 20'h13579, 0, 0), mkTag(31'h77, 0), 6'd1, 2'd0, 2'd0, 1'b0);
    check(fetchValid && fetchInsn == {20'hABCDE, 20'h13579}, "R10 resumes",
          {fetchValid, fetchInsn}, {1'b1, 20'hABCDE, 20'h13579});
  endtask

  task automatic testStream();
    logic [19:0] his [4];
    his[0] = 20'h11111; his[1] = 20'h22223; his[2] = 20'hFEDCB; his[3] = 20'h00001;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      rdData = mkData(his[i], 20'(i), 0, 0); rdTag = mkTag(31'(i), 0); rdValid = 1'b1;
      @(posedge clk); #1;
      if (i > 0)
        check(fetchValid && fetchInsn == {his[i-1], 20'(i-1)}, "R11 stream order",
              fetchInsn, {his[i-1], 20'(i-1)});
      @(negedge clk);
    end
    rdValid = 1'b0;
    @(posedge clk); #1;
    check(fetchValid && fetchInsn == {his[3], 20'd3}, "R11 stream last", fetchInsn, {his[3], 20'd3});
  endtask

  task automatic testStrayAck();
    ackRefetch();
    check(!refetchReq && rdReady, "R12 stray ack", {refetchReq, rdReady}, 2'b01);
    lookup(mkData(20'h4, 20'h5, 0, 0), mkTag(31'h6, 0), 6'd2, 2'd2, 2'd2, 1'b0);
    check(fetchValid && !errValid, "R12 lookup unaffected", {fetchValid, errValid}, 2'b10);
  endtask

  initial begin
    #1;
    check(rdReady == 1'b1 && !fetchValid, "R1 in reset", {rdReady, fetchValid}, 2'b10);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testClean();
    testBadData(1, 0, 2'd2, 2'd2, 6'd9,  "R3 upper half");
    testBadData(0, 1, 2'd0, 2'd1, 6'd63, "R4 lower half");
    testBadData(1, 1, 2'd3, 2'd0, 6'd30, "R13 both halves");
    testBadTag(0, 1'b0, "R5 tag");
    testBadTag(1, 1'b1, "R7 tag wins");
    testStallIgnored();
    testStream();
    testStrayAck();
    finishRun();
  end
endmodule